// File: doc/BRIEF.md
# Processor Port with Unit Select

This block is the processor-side access port of one buffer unit. A small processor shares a bus with up to four such units. Each unit carries a static 2-bit identity, so the four units together cover four times the word count of one unit: 64K words with the default 14-bit pointer. A unit-addressed mode command gives the unit exactly one owner. The owner is the crate bus, the processor or the front-panel write port, and the mode register shows which one it is as a one-hot status. The processor moves data through four transfer commands: load the pointer, write a word and advance, read back a unit's pointer, and read a word and advance.

Commands arrive on a valid/ready stream. When the port accepts a command it issues the write or read strobe to the unit's RAM in that same cycle, and the RAM address is always the shared pointer. Read commands return one word on a second valid/ready stream. The response stays on the outputs until the processor takes it. Until then, and while a RAM read is in flight, `cmd_ready` stays low. No command is lost under back-pressure, because a command moves only in a cycle where `cmd_valid` and `cmd_ready` are both high. Transfers give valid results only while the processor owns the unit. In any other mode a transfer leaves the RAM and the pointer alone, and a read answers with a zero word marked as not hit.

Top module: `ppu_port`

## Requirements
- R1: After reset no owner is set, the pointer (seen on `mem_addr`) is 0, `rsp_valid` is low and `cmd_ready` is high.
- R2: A mode command (`cmd_op`=1) whose `cmd_arg[5:4]` equals `unit_id` sets ownership from `cmd_arg[3:2]`: 1 gives `own_bus`, 2 gives `own_proc`, 3 gives `own_panel`. Exactly one owner flag is high afterwards.
- R3: A mode command with code 0 in `cmd_arg[3:2]`, or one addressed to another unit, leaves the ownership flags unchanged.
- R4: When no response is pending, mode commands are accepted whatever the current owner is.
- R5: A pointer write (`cmd_op`=2) in processor mode loads `cmd_arg[ADDR_W-1:0]` into the pointer.
- R6: A data write (`cmd_op`=3) in processor mode pulses `mem_we` in the accept cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to `cmd_arg`. The pointer then advances by one.
- R7: A data read (`cmd_op`=5) in processor mode pulses `mem_re` in the accept cycle at the pointer. The pointer then advances by one. Two cycles after acceptance, the response carries the stored word with `rsp_hit` set.
- R8: A pointer read (`cmd_op`=4) answers one cycle after acceptance. If `cmd_arg[1:0]` equals `unit_id` in processor mode, the data is `unit_id` placed at bits `ADDR_W+1:ADDR_W` above the pointer, and `rsp_hit` is 1. Any other index gives data 0 and `rsp_hit` 0.
- R9: Outside processor mode, transfers raise no RAM strobe and leave the pointer unchanged. Reads answer after one cycle with data 0 and `rsp_hit` 0.
- R10: A response holds `rsp_valid`, `rsp_data` and `rsp_hit` steady until `rsp_ready` is high. `cmd_ready` is low while a response is pending or being fetched.
- R11: The pointer wraps from its all-ones value to 0 when it advances.
- R12: Command codes 0, 6 and 7 are accepted and have no effect on ownership, pointer, RAM or responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_id | input | 2 | Static identity of this unit |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Port can take a command |
| cmd_op | input | 3 | Command code (1 mode, 2 pointer write, 3 data write, 4 pointer read, 5 data read) |
| cmd_arg | input | DATA_W | Command argument |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_data | output | DATA_W | Response word |
| rsp_hit | output | 1 | Response carries valid data from this unit |
| own_bus | output | 1 | Crate bus owns the unit |
| own_proc | output | 1 | Processor owns the unit |
| own_panel | output | 1 | Front-panel write port owns the unit |
| mem_addr | output | ADDR_W | RAM address, always the pointer |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe (data one cycle later) |
| mem_rdata | input | DATA_W | RAM read data |

## Verification
The bench builds the port with `ADDR_W`=5 and `DATA_W`=16, with `unit_id` tied to 2. A 32-word pointer lets random data traffic wrap the pointer many times, and a directed test drives the wrap at 31. The 5-bit pointer sits below the 2-bit unit field, so pointer readback checks that the unit identity lands at bits 6:5. Random mode commands go to all four unit addresses and use all four codes, so ownership changes, no-change codes and foreign-unit commands all occur in between transfers.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_MODE   = 3'd1,
    OP_PTR_WR = 3'd2,
    OP_DAT_WR = 3'd3,
    OP_PTR_RD = 3'd4,
    OP_DAT_RD = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    MC_KEEP  = 2'd0,
    MC_BUS   = 2'd1,
    MC_PROC  = 2'd2,
    MC_PANEL = 2'd3
  } mode_code_e;

  typedef struct packed {
    logic panel;
    logic proc;
    logic bus;
  } own_t;

  localparam int UNIT_FIELD_LSB = 4;
  localparam int MODE_FIELD_LSB = 2;
endpackage

// File: rtl/ppu_mode_reg.sv
module ppu_mode_reg
  import ppu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] unit_id,
  input  logic       set_stb,
  input  logic [1:0] set_unit,
  input  logic [1:0] set_code,
  output own_t       own
);
  mode_code_e code;
  logic       take;

  assign code = mode_code_e'(set_code);
  assign take = set_stb && (set_unit == unit_id) && (code != MC_KEEP);

  function automatic own_t decode_owner(mode_code_e c);
    own_t o;
    o = '0;
    case (c)
      MC_BUS:   o.bus   = 1'b1;
      MC_PROC:  o.proc  = 1'b1;
      MC_PANEL: o.panel = 1'b1;
      default:  o = '0;
    endcase
    return o;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own <= '0;
    end else if (take) begin
      own <= decode_owner(code);
    end
  end

  assert_owner_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own));
  assert_proc_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb && (set_unit == unit_id) && (set_code == 2'd2) |=> own.proc);
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb && ((set_code == 2'd0) || (set_unit != unit_id)) |=> $stable(own));
endmodule

// File: rtl/ppu_pointer.sv
module ppu_pointer #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (step) begin
      ptr <= ptr + ONE;
    end
  end

  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && (&ptr) |=> (ptr == '0));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/ppu_xfer_ctl.sv
module ppu_xfer_ctl
  import ppu_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        unit_id,
  input  logic              own_proc,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        sel_idx,
  output logic              cmd_ready,
  output logic              mode_stb,
  output logic              ptr_load,
  output logic              ptr_step,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit
);
  op_e               op;
  logic              accept;
  logic              need_rsp;
  logic              ptr_rd_ok;
  logic [DATA_W-1:0] ptr_word;
  logic              fetch_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !fetch_q && !rsp_valid_q;
  assign accept    = cmd_valid && cmd_ready;
  assign mode_stb  = accept && (op == OP_MODE);
  assign ptr_load  = accept && own_proc && (op == OP_PTR_WR);
  assign mem_we    = accept && own_proc && (op == OP_DAT_WR);
  assign mem_re    = accept && own_proc && (op == OP_DAT_RD);
  assign ptr_step  = mem_we || mem_re;
  assign need_rsp  = accept && ((op == OP_PTR_RD) || (op == OP_DAT_RD));
  assign ptr_rd_ok = own_proc && (op == OP_PTR_RD) && (sel_idx == unit_id);

  always_comb begin
    ptr_word = '0;
    ptr_word[ADDR_W-1:0]  = ptr;
    ptr_word[ADDR_W +: 2] = unit_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= 1'b0;
    end else if (fetch_q) begin
      fetch_q     <= 1'b0;
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= mem_rdata;
      rsp_hit_q   <= 1'b1;
    end else if (rsp_valid_q) begin
      if (rsp_ready) rsp_valid_q <= 1'b0;
    end else if (mem_re) begin
      fetch_q <= 1'b1;
    end else if (need_rsp) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= ptr_rd_ok ? ptr_word : '0;
      rsp_hit_q   <= ptr_rd_ok;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_hit   = rsp_hit_q;

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_data == '0));
  assert_fetch_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_re, 2) |-> rsp_valid && rsp_hit);
endmodule

// File: rtl/ppu_port.sv
module ppu_port
  import ppu_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        unit_id,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              own_bus,
  output logic              own_proc,
  output logic              own_panel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  own_t              own;
  logic              mode_stb;
  logic              ptr_load;
  logic              ptr_step;
  logic [ADDR_W-1:0] ptr;

  ppu_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_id  (unit_id),
    .set_stb  (mode_stb),
    .set_unit (cmd_arg[UNIT_FIELD_LSB +: 2]),
    .set_code (cmd_arg[MODE_FIELD_LSB +: 2]),
    .own      (own)
  );

  ppu_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (cmd_arg[ADDR_W-1:0]),
    .step     (ptr_step),
    .ptr      (ptr)
  );

  ppu_xfer_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_id   (unit_id),
    .own_proc  (own.proc),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .sel_idx   (cmd_arg[1:0]),
    .cmd_ready (cmd_ready),
    .mode_stb  (mode_stb),
    .ptr_load  (ptr_load),
    .ptr_step  (ptr_step),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .ptr       (ptr),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_hit   (rsp_hit)
  );

  assign own_bus   = own.bus;
  assign own_proc  = own.proc;
  assign own_panel = own.panel;
  assign mem_addr  = ptr;
  assign mem_wdata = cmd_arg;

  assert_strobe_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> own_proc);
  assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  assert_idle_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !own_proc && $past(!own_proc) |-> $stable(mem_addr));
endmodule

// File: tb/tb_ppu_port.sv
module tb_ppu_port;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] MY_ID = 2'd2;
  localparam logic [2:0] C_MODE = 3'd1, C_PW = 3'd2, C_DW = 3'd3, C_PR = 3'd4, C_DR = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [DW-1:0] cmd_arg = '0;
  logic cmd_ready, rsp_valid, rsp_hit, own_bus, own_proc, own_panel, mem_we, mem_re;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [2:0] exp_own;
  logic [AW-1:0] exp_ptr;
  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  ppu_port #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .unit_id(MY_ID),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .own_bus(own_bus), .own_proc(own_proc), .own_panel(own_panel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr];
    end
  end

  function automatic logic [2:0] owner_of(logic [1:0] code);
    case (code)
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      2'd3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [DW-1:0] ptr_word(logic [AW-1:0] p);
    logic [DW-1:0] w;
    w = '0;
    w[AW-1:0] = p;
    w[AW +: 2] = MY_ID;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [DW-1:0] arg);
    bit proc, is_rd, hit;
    int lat;
    logic [DW-1:0] exp_d;
    string tg;
    proc = exp_own[1];
    @(negedge clk);
    chk(cmd_ready === 1'b1, (op == C_MODE) ? "R4" : "R10", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    #1;
    tg = proc ? ((op == C_DR) ? "R7" : "R6") : "R9";
    chk(mem_we === (proc && op == C_DW), tg, 32'(mem_we), 32'(proc && op == C_DW));
    chk(mem_re === (proc && op == C_DR), tg, 32'(mem_re), 32'(proc && op == C_DR));
    if (proc && (op == C_DW || op == C_DR))
      chk(mem_addr === exp_ptr, tg, 32'(mem_addr), 32'(exp_ptr));
    is_rd = (op == C_PR) || (op == C_DR);
    lat = 1; exp_d = '0; hit = 1'b0;
    if (op == C_DR && proc) begin lat = 2; exp_d = shadow[exp_ptr]; hit = 1'b1; end
    if (op == C_PR && proc && arg[1:0] == MY_ID) begin exp_d = ptr_word(exp_ptr); hit = 1'b1; end
    case (op)
      C_MODE: if (arg[5:4] == MY_ID && arg[3:2] != 2'd0) exp_own = owner_of(arg[3:2]);
      C_PW:   if (proc) exp_ptr = arg[AW-1:0];
      C_DW:   if (proc) begin shadow[exp_ptr] = arg; exp_ptr = exp_ptr + 1'b1; end
      C_DR:   if (proc) exp_ptr = exp_ptr + 1'b1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    tg = (op == C_MODE) ? ((arg[5:4] == MY_ID && arg[3:2] != 2'd0) ? "R2" : "R3")
       : (op == C_PW && proc) ? "R5" : (op > 3'd5 || op == 3'd0) ? "R12" : proc ? "R6" : "R9";
    chk({own_panel, own_proc, own_bus} === exp_own, tg, 32'({own_panel, own_proc, own_bus}), 32'(exp_own));
    chk(mem_addr === exp_ptr, tg, 32'(mem_addr), 32'(exp_ptr));
    if (is_rd) begin
      tg = (op == C_DR && proc) ? "R7" : (op == C_PR && proc) ? "R8" : "R9";
      if (lat == 2) begin
        chk(rsp_valid === 1'b0, tg, 32'(rsp_valid), 0);
        @(negedge clk);
      end
      chk(rsp_valid === 1'b1, tg, 32'(rsp_valid), 1);
      chk(rsp_hit === hit, tg, 32'(rsp_hit), 32'(hit));
      chk(rsp_data === exp_d, tg, 32'(rsp_data), 32'(exp_d));
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R10", 32'(rsp_valid), 0);
    end else begin
      chk(rsp_valid === 1'b0, (op > 3'd5 || op == 3'd0) ? "R12" : tg, 32'(rsp_valid), 0);
    end
  endtask

  function automatic logic [DW-1:0] mode_arg(logic [1:0] unit, logic [1:0] code);
    logic [DW-1:0] a;
    a = DW'($urandom);
    a[5:4] = unit;
    a[3:2] = code;
    return a;
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    exp_own = '0; exp_ptr = '0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk({own_panel, own_proc, own_bus} === 3'b000, "R1", 32'({own_panel, own_proc, own_bus}), 0);
    chk(mem_addr === '0, "R1", 32'(mem_addr), 0);
    chk(rsp_valid === 1'b0, "R1", 32'(rsp_valid), 0);
    chk(cmd_ready === 1'b1, "R1", 32'(cmd_ready), 1);

    // Transfers with no owner (R9), then ownership changes (R2, R3, R4)
    do_op(C_DW, 16'hbeef);
    do_op(C_DR, 16'h0);
    do_op(C_PR, 16'(MY_ID));
    do_op(C_MODE, mode_arg(MY_ID, 2'd3));
    do_op(C_MODE, mode_arg(2'd1, 2'd2));
    do_op(C_MODE, mode_arg(MY_ID, 2'd0));
    do_op(C_MODE, mode_arg(MY_ID, 2'd1));
    do_op(C_MODE, mode_arg(MY_ID, 2'd2));
    // Pointer load, write, read back, wrap at the top (R5, R6, R7, R8, R11)
    do_op(C_PW, 16'(DEPTH - 2));
    do_op(C_DW, 16'h1234);
    do_op(C_DW, 16'h5678);
    do_op(C_PR, 16'(MY_ID));
    do_op(C_PR, 16'd1);
    do_op(C_PW, 16'(DEPTH - 1));
    do_op(C_DR, 16'h0);
    do_op(C_PW, 16'(DEPTH - 2));
    do_op(C_DR, 16'h0);
    do_op(C_DR, 16'h0);
    do_op(3'd6, 16'hffff);
    do_op(3'd0, 16'h0007);

    // Back-pressure on a held response (R10)
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = C_PR; cmd_arg = 16'(MY_ID);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid === 1'b1 && rsp_data === ptr_word(exp_ptr), "R10", 32'(rsp_data), 32'(ptr_word(exp_ptr)));
      chk(cmd_ready === 1'b0, "R10", 32'(cmd_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", 32'(rsp_valid), 0);

    // Random traffic
    for (int n = 0; n < 500; n++) begin
      int r;
      logic [DW-1:0] a;
      r = int'($urandom % 12);
      a = DW'($urandom);
      if (r < 2) begin
        a = mode_arg(($urandom % 10 < 6) ? MY_ID : 2'($urandom), ($urandom % 4 == 0) ? 2'd0
                     : ($urandom % 3 == 0) ? 2'($urandom) : 2'd2);
        do_op(C_MODE, a);
      end
      else if (r < 3)  do_op(C_PW, a);
      else if (r < 6)  do_op(C_DW, a);
      else if (r < 7)  do_op(C_PR, a);
      else if (r < 10) do_op(C_DR, a);
      else if (r < 11) do_op(3'd0, a);
      else             do_op(3'd7, a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule